// File: doc/BRIEF.md
# IDE Channel Register Window

This block is the memory-mapped front end of one IDE channel. It sits in a 4 KiB address window. Each access carries an address, a write enable, a byte size of 1, 2 or 4, and write data. The block works out which register the access targets and checks that the width is allowed for that register. Data-port, taskfile, status and command accesses go out on a drive-side port to the drive core, which lies outside this block. Two registers live inside the block: a 32-bit timing register, and a 32-bit interrupt state register that shows the DMA and disk interrupt lines.

The register index is the address shifted right by four, so registers are spaced 16 bytes apart. If an access targets no register, or uses a width the register does not allow, a read returns all-ones and a write does nothing. The DMA interrupt and the disk interrupt each pass straight through to their own output pin. The interrupt state register mirrors both lines. Software clears the latched DMA bit by writing a one to it.

Accesses are acknowledged by a small state machine with three states:

- `ST_IDLE`: no access was taken on the last edge.
- `ST_RD_ACK`: a read was taken; `acc_done` is high and `acc_rdata` holds the result.
- `ST_WR_ACK`: a write was taken; `acc_done` is high.

On every edge the next state is picked from the current input alone:

- A valid read goes to `ST_RD_ACK`.
- A valid write goes to `ST_WR_ACK`.
- No valid access goes to `ST_IDLE`.

So any state may move to any other, and back-to-back accesses are accepted every cycle.

Top module: `ide_reg_window`

## Requirements
- R1: The register index is `acc_addr >> 4`. Index 0 is the data port and accepts only sizes 2 and 4. It is forwarded with `drv_sel` = 0.
- R2: Indices 1 to 7 are taskfile registers and accept only size 1. They are forwarded with `drv_sel` = 1 and `drv_reg` equal to the index.
- R3: Indices 0x08 and 0x16 accept only size 1. They are forwarded with `drv_sel` = 2: a read there returns device status and a write there is a device command.
- R4: Index 0x20 is a 32-bit timing register that accepts only size 4. A read returns the last value written to it.
- R5: Index 0x30 is the interrupt state register and accepts only size 4 reads.
  - Bit 31 is set when `dma_irq_in` rises and cleared when it falls.
  - Bit 30 does the same for `disk_irq_in`.
  - Bits 29..0 read as zero.
- R6: A size-4 write to index 0x30 with data bit 31 set clears bit 31. All other written bits are ignored. If `dma_irq_in` rises on the same edge, the rise wins and bit 31 stays set.
- R7: A read of an unmapped index, or with a disallowed size, returns 0xFFFFFFFF and raises no `drv_valid`. A disallowed write raises no `drv_valid` and changes no register.
- R8: `dma_irq_out` follows `dma_irq_in` and `disk_irq_out` follows `disk_irq_in`, with no delay.
- R9: Reset clears the timing register, the interrupt state register and `acc_done`.
- R10: Every valid access is acknowledged by `acc_done` on the cycle after it is accepted. Data is little-endian:
  - a size-1 access uses bits 7..0;
  - a size-2 access uses bits 15..0;
  - read data from the drive is zero-extended above its size;
  - write data to the drive is zeroed above its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address inside the window |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_done | output | 1 | Access acknowledge, one cycle after acceptance |
| acc_rdata | output | 32 | Read result, valid while acknowledging a read |
| drv_valid | output | 1 | Forwarded access to the drive core |
| drv_we | output | 1 | Forwarded direction |
| drv_sel | output | 2 | 0 data port, 1 taskfile, 2 status/command |
| drv_reg | output | 3 | Taskfile register number (0 otherwise) |
| drv_size | output | 3 | Forwarded access size |
| drv_wdata | output | 32 | Forwarded write data, lanes above the size zeroed |
| drv_rdata | input | 32 | Drive core read data, same cycle as `drv_valid` |
| dma_irq_in | input | 1 | DMA interrupt level |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | DMA interrupt forwarded |
| disk_irq_out | output | 1 | Disk interrupt forwarded |

## Verification
On every cycle, the assertions check four things:

- every access is acknowledged on the next cycle;
- taskfile and unmapped accesses with the wrong width never reach the drive port;
- the timing register changes only on a legal 32-bit write;
- the interrupt bits track rises and falls of their lines, and the DMA bit clears on a write-one when its line is low.

Only the bench's scenarios can show the rest:

- the read values through both status aliases;
- lane zero-extension of drive data;
- all-ones on wrong-width reads;
- a rising DMA line beating a simultaneous clear;
- the pass-through of the two interrupt outputs.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_HALF = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd4;

    localparam logic [1:0] DSEL_DATA = 2'd0;
    localparam logic [1:0] DSEL_TASK = 2'd1;
    localparam logic [1:0] DSEL_CTRL = 2'd2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_TASK,
        TGT_CTRL,
        TGT_TIMING,
        TGT_IRQ
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ACK,
        ST_WR_ACK
    } ack_state_e;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [2:0] sz);
        logic [WORD_W-1:0] m;
        unique case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            SZ_WORD: m = 32'hFFFF_FFFF;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int IDX_LSB    = 4,
    parameter int IDX_DATA   = 0,
    parameter int IDX_TF_LO  = 1,
    parameter int IDX_TF_HI  = 7,
    parameter int IDX_CTRL_A = 8,
    parameter int IDX_CTRL_B = 22,
    parameter int IDX_TIMING = 32,
    parameter int IDX_IRQ    = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output tgt_e              tgt,
    output logic [2:0]        tf_reg
);
    localparam int IDX_W = ADDR_W - IDX_LSB;

    logic [IDX_W-1:0] idx;
    int               idx_i;

    always_comb begin
        idx    = addr[ADDR_W-1:IDX_LSB];
        idx_i  = int'(idx);
        tgt    = TGT_NONE;
        tf_reg = 3'd0;
        if (idx_i == IDX_DATA) begin
            if (size == SZ_HALF || size == SZ_WORD) tgt = TGT_DATA;
        end else if (idx_i >= IDX_TF_LO && idx_i <= IDX_TF_HI) begin
            if (size == SZ_BYTE) begin
                tgt    = TGT_TASK;
                tf_reg = idx[2:0];
            end
        end else if (idx_i == IDX_CTRL_A || idx_i == IDX_CTRL_B) begin
            if (size == SZ_BYTE) tgt = TGT_CTRL;
        end else if (idx_i == IDX_TIMING) begin
            if (size == SZ_WORD) tgt = TGT_TIMING;
        end else if (idx_i == IDX_IRQ) begin
            if (size == SZ_WORD) tgt = TGT_IRQ;
        end
    end

endmodule

// File: rtl/ide_win_irq.sv
module ide_win_irq
    import ide_win_pkg::*;
#(
    parameter int                 NUM_IRQ  = 2,
    parameter logic [NUM_IRQ-1:0] CLR_MASK = 2'b01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lvl,
    input  logic               clr_req,
    output logic [WORD_W-1:0]  word
);
    logic [NUM_IRQ-1:0] prev_q;
    logic [NUM_IRQ-1:0] bit_q;
    logic [NUM_IRQ-1:0] bit_d;

    always_comb begin
        bit_d = bit_q;
        for (int n = 0; n < NUM_IRQ; n++) begin
            if (lvl[n] && !prev_q[n])      bit_d[n] = 1'b1;
            else if (!lvl[n] && prev_q[n]) bit_d[n] = 1'b0;
            else if (CLR_MASK[n] && clr_req) bit_d[n] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            bit_q  <= '0;
        end else begin
            prev_q <= lvl;
            bit_q  <= bit_d;
        end
    end

    // Line n sits at bit (WORD_W-1-n), counting down from the top.
    always_comb begin
        word = '0;
        for (int n = 0; n < NUM_IRQ; n++) word[WORD_W-1-n] = bit_q[n];
    end

endmodule

// File: rtl/ide_reg_window.sv
module ide_reg_window
    import ide_win_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int IDX_LSB    = 4,
    parameter int IDX_DATA   = 0,
    parameter int IDX_TF_LO  = 1,
    parameter int IDX_TF_HI  = 7,
    parameter int IDX_CTRL_A = 8,
    parameter int IDX_CTRL_B = 22,
    parameter int IDX_TIMING = 32,
    parameter int IDX_IRQ    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              acc_done,
    output logic [31:0]       acc_rdata,
    output logic              drv_valid,
    output logic              drv_we,
    output logic [1:0]        drv_sel,
    output logic [2:0]        drv_reg,
    output logic [2:0]        drv_size,
    output logic [31:0]       drv_wdata,
    input  logic [31:0]       drv_rdata,
    input  logic              dma_irq_in,
    input  logic              disk_irq_in,
    output logic              dma_irq_out,
    output logic              disk_irq_out
);
    localparam int NUM_IRQ = 2;

    tgt_e              tgt;
    logic [2:0]        tf_reg;
    logic [WORD_W-1:0] timing_q;
    logic [WORD_W-1:0] irq_word;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] lane;
    logic              clr_req;
    ack_state_e        state_q;
    ack_state_e        state_d;

    ide_win_decode #(
        .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_DATA(IDX_DATA),
        .IDX_TF_LO(IDX_TF_LO), .IDX_TF_HI(IDX_TF_HI),
        .IDX_CTRL_A(IDX_CTRL_A), .IDX_CTRL_B(IDX_CTRL_B),
        .IDX_TIMING(IDX_TIMING), .IDX_IRQ(IDX_IRQ)
    ) i_decode (
        .addr   (acc_addr),
        .size   (acc_size),
        .tgt    (tgt),
        .tf_reg (tf_reg)
    );

    assign clr_req = acc_valid && acc_we && (tgt == TGT_IRQ) && acc_wdata[WORD_W-1];

    ide_win_irq #(
        .NUM_IRQ  (NUM_IRQ),
        .CLR_MASK (2'b01)
    ) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     ({disk_irq_in, dma_irq_in}),
        .clr_req (clr_req),
        .word    (irq_word)
    );

    assign dma_irq_out  = dma_irq_in;
    assign disk_irq_out = disk_irq_in;

    // Drive-side forwarding
    always_comb begin
        lane      = lane_mask(acc_size);
        drv_valid = 1'b0;
        drv_sel   = DSEL_DATA;
        drv_reg   = 3'd0;
        unique case (tgt)
            TGT_DATA: drv_valid = acc_valid;
            TGT_TASK: begin
                drv_valid = acc_valid;
                drv_sel   = DSEL_TASK;
                drv_reg   = tf_reg;
            end
            TGT_CTRL: begin
                drv_valid = acc_valid;
                drv_sel   = DSEL_CTRL;
            end
            default: drv_valid = 1'b0;
        endcase
        drv_we    = acc_we;
        drv_size  = acc_size;
        drv_wdata = acc_wdata & lane;
    end

    // Read selection
    always_comb begin
        unique case (tgt)
            TGT_DATA, TGT_TASK, TGT_CTRL: rd_mux = drv_rdata & lane;
            TGT_TIMING:                   rd_mux = timing_q;
            TGT_IRQ:                      rd_mux = irq_word;
            default:                      rd_mux = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (acc_valid && acc_we && tgt == TGT_TIMING) timing_q <= acc_wdata;
            if (acc_valid && !acc_we)                     rdata_q  <= rd_mux;
        end
    end

    // Acknowledge state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Acknowledge state machine: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RD_ACK, ST_WR_ACK: begin
                if (!acc_valid)  state_d = ST_IDLE;
                else if (acc_we) state_d = ST_WR_ACK;
                else             state_d = ST_RD_ACK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Acknowledge state machine: outputs
    always_comb begin
        acc_done  = 1'b0;
        acc_rdata = '0;
        unique case (state_q)
            ST_RD_ACK: begin
                acc_done  = 1'b1;
                acc_rdata = rdata_q;
            end
            ST_WR_ACK: acc_done = 1'b1;
            default:   acc_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/ide_win_chk.sv
module ide_win_chk #(
    parameter int ADDR_W     = 12,
    parameter int IDX_LSB    = 4,
    parameter int IDX_TIMING = 32,
    parameter int IDX_IRQ    = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic              acc_done,
    input logic [31:0]       acc_rdata,
    input logic              drv_valid,
    input logic              dma_irq_in,
    input logic              disk_irq_in,
    input logic [31:0]       timing_q,
    input logic [31:0]       irq_word
);
    logic [ADDR_W-IDX_LSB-1:0] idx;
    int                        idx_i;
    logic                      tim_wr_ok;

    always_comb begin
        idx       = acc_addr[ADDR_W-1:IDX_LSB];
        idx_i     = int'(idx);
        tim_wr_ok = acc_valid && acc_we && idx_i == IDX_TIMING && acc_size == 3'd4;
    end

    a_r10_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> acc_done);

    a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !acc_done);

    a_r2_taskfile_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && idx_i >= 1 && idx_i <= 7 && acc_size != 3'd1) |-> !drv_valid);

    a_r7_timing_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we && idx_i == IDX_TIMING && acc_size != 3'd4)
        |=> (acc_rdata == 32'hFFFF_FFFF));

    a_r7_unmapped_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && idx_i > 7 && idx_i != 8 && idx_i != 22) |-> !drv_valid);

    a_r4_timing_write: assert property (@(posedge clk) disable iff (!rst_n)
        tim_wr_ok |=> (timing_q == $past(acc_wdata)));

    a_r7_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_wr_ok |=> $stable(timing_q));

    a_r5_dma_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_irq_in) |=> irq_word[31]);

    a_r5_dma_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_irq_in) |=> !irq_word[31]);

    a_r5_disk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disk_irq_in) |=> irq_word[30]);

    a_r5_disk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disk_irq_in) |=> !irq_word[30]);

    a_r6_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && idx_i == IDX_IRQ && acc_size == 3'd4
         && acc_wdata[31] && !dma_irq_in) |=> !irq_word[31]);

endmodule

bind ide_reg_window ide_win_chk #(
    .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_TIMING(IDX_TIMING), .IDX_IRQ(IDX_IRQ)
) i_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .acc_rdata(acc_rdata), .drv_valid(drv_valid),
    .dma_irq_in(dma_irq_in), .disk_irq_in(disk_irq_in),
    .timing_q(timing_q), .irq_word(irq_word)
);

// File: tb/test_ide_reg_window.sv
module test_ide_reg_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_we = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [2:0]  acc_size = 3'd4;
    logic [31:0] acc_wdata = '0;
    logic        acc_done;
    logic [31:0] acc_rdata;
    logic        drv_valid, drv_we;
    logic [1:0]  drv_sel;
    logic [2:0]  drv_reg, drv_size;
    logic [31:0] drv_wdata, drv_rdata;
    logic        dma_irq_in = 1'b0;
    logic        disk_irq_in = 1'b0;
    logic        dma_irq_out, disk_irq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          cmp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    // Drive-core stub: low byte carries the selector and register number.
    assign drv_rdata = 32'h1234_5600 | {24'h0, drv_sel, 3'b000, drv_reg};

    ide_reg_window i_ide_reg_window (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata), .drv_valid(drv_valid),
        .drv_we(drv_we), .drv_sel(drv_sel), .drv_reg(drv_reg),
        .drv_size(drv_size), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .dma_irq_in(dma_irq_in), .disk_irq_in(disk_irq_in),
        .dma_irq_out(dma_irq_out), .disk_irq_out(disk_irq_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issues one access, pushes the expected result, and
    // captures the drive-side view while the request is held.
    logic       snap_valid, snap_we;
    logic [1:0] snap_sel;
    logic [2:0] snap_reg;
    logic [31:0] snap_wdata;

    task automatic access(input bit we, input logic [11:0] addr, input logic [2:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp,
                          input bit cmp, input string tag);
        sb_item_t it;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_we    = we;
        acc_addr  = addr;
        acc_size  = sz;
        acc_wdata = wd;
        it.exp = exp;
        it.cmp = cmp;
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        snap_valid = drv_valid;
        snap_we    = drv_we;
        snap_sel   = drv_sel;
        snap_reg   = drv_reg;
        snap_wdata = drv_wdata;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops one expected item per acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && acc_done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected acknowledge", 32'h1, 32'h0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (it.cmp) check(acc_rdata == it.exp, it.tag, acc_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(acc_done == 1'b0, "R9 acc_done low in reset", {31'h0, acc_done}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R9: registers cleared
        access(1'b0, 12'h200, 3'd4, 32'h0, 32'h0, 1'b1, "R9 timing reset value");
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h0, 1'b1, "R9 irq state reset value");

        // R1: data port
        access(1'b0, 12'h000, 3'd4, 32'h0, 32'h1234_5600, 1'b1, "R1 data word read");
        check(snap_valid && snap_sel == 2'd0, "R1 data forwarded sel0", {30'h0, snap_sel}, 32'h0);
        access(1'b0, 12'h004, 3'd2, 32'h0, 32'h0000_5600, 1'b1, "R10 R1 data half read zero-extended");
        access(1'b0, 12'h000, 3'd1, 32'h0, 32'hFFFF_FFFF, 1'b1, "R7 data byte read all-ones");
        check(!snap_valid, "R7 data byte not forwarded", {31'h0, snap_valid}, 32'h0);
        access(1'b1, 12'h000, 3'd2, 32'hDEAD_BEEF, 32'h0, 1'b0, "R1 data half write");
        check(snap_valid && snap_we && snap_wdata == 32'h0000_BEEF, "R10 R1 data half write lanes",
              snap_wdata, 32'h0000_BEEF);

        // R2: taskfile
        access(1'b0, 12'h050, 3'd1, 32'h0, 32'h0000_0045, 1'b1, "R2 taskfile reg5 byte read");
        check(snap_valid && snap_sel == 2'd1 && snap_reg == 3'd5, "R2 taskfile forward reg5",
              {27'h0, snap_sel, snap_reg}, {27'h0, 2'd1, 3'd5});
        access(1'b0, 12'h070, 3'd2, 32'h0, 32'hFFFF_FFFF, 1'b1, "R2 R7 taskfile half read all-ones");
        check(!snap_valid, "R2 taskfile half not forwarded", {31'h0, snap_valid}, 32'h0);
        access(1'b1, 12'h010, 3'd1, 32'h0000_01A7, 32'h0, 1'b0, "R2 taskfile reg1 write");
        check(snap_valid && snap_reg == 3'd1 && snap_wdata == 32'h0000_00A7,
              "R2 taskfile reg1 write byte lane", snap_wdata, 32'h0000_00A7);

        // R3: status / command at both indices
        access(1'b0, 12'h080, 3'd1, 32'h0, 32'h0000_0080, 1'b1, "R3 status read index 0x08");
        access(1'b0, 12'h160, 3'd1, 32'h0, 32'h0000_0080, 1'b1, "R3 status read index 0x16");
        access(1'b1, 12'h160, 3'd1, 32'h0000_00EC, 32'h0, 1'b0, "R3 command write index 0x16");
        check(snap_valid && snap_we && snap_sel == 2'd2 && snap_wdata == 32'h0000_00EC,
              "R3 command forwarded sel2", snap_wdata, 32'h0000_00EC);
        access(1'b0, 12'h080, 3'd4, 32'h0, 32'hFFFF_FFFF, 1'b1, "R3 R7 status word read all-ones");

        // R4: timing register
        access(1'b1, 12'h200, 3'd4, 32'hA5C3_0F1E, 32'h0, 1'b0, "R4 timing write");
        access(1'b0, 12'h200, 3'd4, 32'h0, 32'hA5C3_0F1E, 1'b1, "R4 timing readback");
        access(1'b1, 12'h200, 3'd1, 32'h0000_0011, 32'h0, 1'b0, "R7 timing byte write");
        check(!snap_valid, "R7 timing byte write not forwarded", {31'h0, snap_valid}, 32'h0);
        access(1'b0, 12'h200, 3'd4, 32'h0, 32'hA5C3_0F1E, 1'b1, "R7 timing unchanged by byte write");
        access(1'b0, 12'h200, 3'd2, 32'h0, 32'hFFFF_FFFF, 1'b1, "R7 timing half read all-ones");
        access(1'b0, 12'h400, 3'd4, 32'h0, 32'hFFFF_FFFF, 1'b1, "R7 unmapped read all-ones");
        access(1'b1, 12'h400, 3'd4, 32'h1111_1111, 32'h0, 1'b0, "R7 unmapped write");
        check(!snap_valid, "R7 unmapped write not forwarded", {31'h0, snap_valid}, 32'h0);
        access(1'b0, 12'h200, 3'd4, 32'h0, 32'hA5C3_0F1E, 1'b1, "R7 timing unchanged by unmapped write");

        // R8 / R5: interrupt lines
        @(negedge clk);
        dma_irq_in = 1'b1;
        #1;
        check(dma_irq_out == 1'b1 && disk_irq_out == 1'b0, "R8 dma forwarded",
              {30'h0, disk_irq_out, dma_irq_out}, 32'h1);
        idle(2);
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h8000_0000, 1'b1, "R5 dma bit31 set");
        @(negedge clk);
        disk_irq_in = 1'b1;
        #1;
        check(disk_irq_out == 1'b1, "R8 disk forwarded", {31'h0, disk_irq_out}, 32'h1);
        idle(2);
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'hC000_0000, 1'b1, "R5 both bits set");
        access(1'b0, 12'h300, 3'd2, 32'h0, 32'hFFFF_FFFF, 1'b1, "R7 irq half read all-ones");

        // R6: write-one-to-clear
        access(1'b1, 12'h300, 3'd4, 32'h7FFF_FFFF, 32'h0, 1'b0, "R6 write without bit31");
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'hC000_0000, 1'b1, "R6 other bits ignored");
        access(1'b1, 12'h300, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R6 clear bit31");
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h4000_0000, 1'b1, "R6 bit31 cleared, bit30 kept");
        access(1'b1, 12'h300, 3'd1, 32'h0000_0080, 32'h0, 1'b0, "R7 irq byte write");
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h4000_0000, 1'b1, "R7 irq unchanged by byte write");

        // R5: falling lines
        @(negedge clk);
        dma_irq_in  = 1'b0;
        disk_irq_in = 1'b0;
        #1;
        check(dma_irq_out == 1'b0 && disk_irq_out == 1'b0, "R8 lines low forwarded",
              {30'h0, disk_irq_out, dma_irq_out}, 32'h0);
        idle(2);
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h0000_0000, 1'b1, "R5 both bits follow fall");

        // R6: rise on the same edge as a clear wins
        @(negedge clk);
        acc_valid = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = 12'h300;
        acc_size  = 3'd4;
        acc_wdata = 32'h8000_0000;
        dma_irq_in = 1'b1;
        begin
            sb_item_t it;
            it.exp = 32'h0;
            it.cmp = 1'b0;
            it.tag = "R6 simultaneous write";
            sb_q.push_back(it);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        access(1'b0, 12'h300, 3'd4, 32'h0, 32'h8000_0000, 1'b1, "R6 rise beats clear");

        // Back-to-back reads
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b0; acc_addr = 12'h200; acc_size = 3'd4;
        begin
            sb_item_t it;
            it.exp = 32'hA5C3_0F1E; it.cmp = 1'b1; it.tag = "R10 back-to-back first";
            sb_q.push_back(it);
        end
        @(negedge clk);
        acc_addr = 12'h050; acc_size = 3'd1;
        begin
            sb_item_t it;
            it.exp = 32'h0000_0045; it.cmp = 1'b1; it.tag = "R10 back-to-back second";
            sb_q.push_back(it);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;

        idle(4);
        check(sb_q.size() == 0, "R10 all accesses acknowledged", sb_q.size(), 32'h0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule